// File: doc/BRIEF.md
# Read-Ahead Prefetch Buffer

This block sits between the slave side of a PCI target and a master on the processor bus, and serves beat-wise block reads from a small line-organised data store. The store holds four cache lines of four 64-bit beats each, 16 entries in all. Every line slot carries a valid bit and the line address it holds. A slave read whose line is resident is accepted at once, and its data comes back one cycle later. A read whose line is absent causes the processor-bus master to fetch that whole line as a four-beat burst, and the slave waits until the line is complete.

Read-ahead applies only when the enable input is high and the command is a line-type or multiple-type memory read. In that case the block keeps fetching the following sequential lines into free slots, ahead of demand. A line that has been consumed up to its last beat gives its slot back, so streaming continues. A fill of one line can proceed while another, already complete line is being drained.

A strobe marks the end of each PCI block transaction. It discards every buffered line, withdraws a fetch request that has not been accepted yet, and drops the remaining beats of a burst that is already under way. Bus timing is reduced to valid/ready handshakes on both sides.

Top module: `rahead_buf`

## Requirements
- R1: After reset no line is held, `rd_req_ready`, `rd_rsp_valid` and `fetch_valid` are low, and no fetch has been issued.
- R2: A request accepted while `rd_req_valid` and `rd_req_ready` are both high yields `rd_rsp_valid` in the next cycle, with the beat stored for that address. The address is a beat address: bits [1:0] select the beat and the bits above them are the line address.
- R3: A request for an absent line keeps `rd_req_ready` low and issues one fetch with `fetch_line` equal to the request address shifted right by two.
- R4: After `fetch_ready` accepts a fetch, the next four `fill_valid` beats are stored as beats 0, 1, 2 and 3 of that line, and the line becomes readable only after beat 3.
- R5: With `ra_en` low, or with command code 0 (plain memory read) or 3 (treated as plain), only lines that are demanded are fetched.
- R6: With `ra_en` high and command code 1 (read line) or 2 (read multiple), a demand fetch of line L is followed, without further requests, by fetches of L+1, L+2 and so on, as long as a line slot is free.
- R7: In read-ahead mode, accepting beat 3 of a line frees its slot, and the next sequential line is then fetched into it.
- R8: A request that hits a complete line is accepted while a different line is receiving fill beats.
- R9: A cycle with `xact_end` high invalidates all lines, so a later request for a previously held line misses and fetches it again. The same cycle also withdraws a fetch request that has not been accepted and turns read-ahead off.
- R10: Fill beats of a burst in flight at or after `xact_end`, including a beat in the same cycle, are not stored. No new fetch is issued until that burst's four beats have passed.
- R11: A request presented in the same cycle as `xact_end` is not accepted, even if it hits.
- R12: Only one fetch is outstanding at a time, and `fetch_valid` with `fetch_line` holds steady until `fetch_ready`, unless `xact_end` withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Slave read request present |
| rd_req_addr | input | 16 | Beat address of the request |
| rd_req_cmd | input | 2 | Read command code (0 plain, 1 line, 2 multiple) |
| ra_en | input | 1 | Read-ahead enable |
| rd_req_ready | output | 1 | Request accepted this cycle (line resident) |
| rd_rsp_valid | output | 1 | Response data valid |
| rd_rsp_data | output | 64 | Response beat |
| xact_end | input | 1 | End of PCI block transaction, discards all contents |
| fetch_valid | output | 1 | Line fetch request to the processor-bus side |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_line | output | 14 | Line address to fetch |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 64 | Fill beat data |

## Verification
The collision of interest is between a transaction end and a fill beat arriving in the same cycle. The bench raises `xact_end` exactly while the second beat of a demand burst is on `fill_data`. It then asks for that line again, and a clean result is a fresh fetch of the same line followed by correct data. A second overlap, a drain hitting one line while another line fills, is provoked by waiting for `fill_valid` during read-ahead and presenting a hit in that same cycle. There the bench judges immediate acceptance and the returned beat.

// File: rtl/rahead_pkg.sv
package rahead_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2,
        FS_DROP = 2'd3
    } fetch_st_e;

    localparam logic [1:0] CMD_PLAIN = 2'd0;
    localparam logic [1:0] CMD_LINE  = 2'd1;
    localparam logic [1:0] CMD_MULTI = 2'd2;

    function automatic logic cmd_reads_ahead(input logic [1:0] cmd);
        return (cmd == CMD_LINE) || (cmd == CMD_MULTI);
    endfunction

endpackage

// File: rtl/rahead_store.sv
module rahead_store #(
    parameter int LINES = 4,
    parameter int BEATS = 4,
    parameter int DW    = 64
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [$clog2(LINES*BEATS)-1:0]       widx,
    input  logic [DW-1:0]                        wdata,
    input  logic                                 re,
    input  logic [$clog2(LINES*BEATS)-1:0]       ridx,
    output logic [DW-1:0]                        rdata
);
    localparam int ENTRIES = LINES * BEATS;
    localparam int IW      = $clog2(ENTRIES);
    localparam int BB      = $clog2(BEATS);

    logic [DW-1:0] mem_q [ENTRIES];
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem_q[ridx];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R8: a drain never reads the slot that is being filled in the same cycle
    a_r8_no_read_of_filling_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (we && re) |-> (widx[IW-1:BB] != ridx[IW-1:BB]));

endmodule

// File: rtl/rahead_ctrl.sv
module rahead_ctrl
    import rahead_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LINES = 4,
    parameter int BEATS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 rd_req_valid,
    input  logic [AW-1:0]                        rd_req_addr,
    input  logic [1:0]                           rd_req_cmd,
    input  logic                                 ra_en,
    output logic                                 rd_req_ready,
    output logic                                 rsp_valid,
    input  logic                                 xact_end,
    output logic                                 fetch_valid,
    input  logic                                 fetch_ready,
    output logic [AW-$clog2(BEATS)-1:0]          fetch_line,
    input  logic                                 fill_valid,
    output logic                                 st_we,
    output logic [$clog2(LINES*BEATS)-1:0]       st_widx,
    output logic                                 st_re,
    output logic [$clog2(LINES*BEATS)-1:0]       st_ridx
);
    localparam int BB = $clog2(BEATS);
    localparam int SB = $clog2(LINES);
    localparam int LW = AW - BB;
    localparam logic [BB-1:0] LAST_BEAT = BB'(BEATS - 1);

    typedef struct packed {
        logic [LINES-1:0]         valid;
        logic [LINES-1:0][LW-1:0] tag;
        fetch_st_e                st;
        logic [SB-1:0]            fslot;
        logic [LW-1:0]            fline;
        logic [BB-1:0]            cnt;
        logic                     arm;
        logic [LW-1:0]            next_pf;
        logic [SB-1:0]            victim;
        logic                     rsp_valid;
    } ctrl_t;

    ctrl_t q, d;

    logic [LW-1:0]    req_line;
    logic [BB-1:0]    req_beat;
    logic [LINES-1:0] hit_vec;
    logic [LINES-1:0] pf_vec;
    logic             hit;
    logic [SB-1:0]    hit_slot;
    logic             any_free;
    logic [SB-1:0]    free_slot;
    logic             accept;
    logic             fill_last;

    assign req_line = rd_req_addr[AW-1:BB];
    assign req_beat = rd_req_addr[BB-1:0];

    always_comb begin
        hit_slot  = '0;
        free_slot = '0;
        any_free  = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            hit_vec[i] = q.valid[i] && (q.tag[i] == req_line);
            pf_vec[i]  = q.valid[i] && (q.tag[i] == q.next_pf);
            if (hit_vec[i]) begin
                hit_slot = SB'(i);
            end
        end
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!q.valid[i]) begin
                any_free  = 1'b1;
                free_slot = SB'(i);
            end
        end
        hit = |hit_vec;
    end

    assign rd_req_ready = hit && !xact_end;
    assign accept       = rd_req_valid && rd_req_ready;
    assign fill_last    = fill_valid && (q.cnt == LAST_BEAT);

    always_comb begin
        d       = q;
        st_we   = 1'b0;
        st_re   = accept;
        st_ridx = {hit_slot, req_beat};
        st_widx = {q.fslot, q.cnt};

        d.rsp_valid = accept;
        if (accept && (req_beat == LAST_BEAT) && q.arm) begin
            d.valid[hit_slot] = 1'b0;
        end

        case (q.st)
            FS_IDLE: begin
                if (!xact_end) begin
                    if (rd_req_valid && !hit) begin
                        d.st       = FS_REQ;
                        d.fline    = req_line;
                        d.arm      = ra_en && cmd_reads_ahead(rd_req_cmd);
                        d.next_pf  = req_line + LW'(1);
                        d.fslot    = any_free ? free_slot : q.victim;
                        d.tag[d.fslot]   = req_line;
                        d.valid[d.fslot] = 1'b0;
                        if (!any_free) begin
                            d.victim = q.victim + SB'(1);
                        end
                    end else if (q.arm && any_free) begin
                        d.next_pf = q.next_pf + LW'(1);
                        if (!(|pf_vec)) begin
                            d.st             = FS_REQ;
                            d.fline          = q.next_pf;
                            d.fslot          = free_slot;
                            d.tag[free_slot] = q.next_pf;
                        end
                    end
                end
            end
            FS_REQ: begin
                if (fetch_ready) begin
                    d.st  = FS_FILL;
                    d.cnt = '0;
                end
            end
            FS_FILL: begin
                if (fill_valid) begin
                    st_we = 1'b1;
                    d.cnt = q.cnt + BB'(1);
                    if (fill_last) begin
                        d.valid[q.fslot] = 1'b1;
                        d.st             = FS_IDLE;
                    end
                end
            end
            default: begin
                if (fill_valid) begin
                    d.cnt = q.cnt + BB'(1);
                    if (fill_last) begin
                        d.st = FS_IDLE;
                    end
                end
            end
        endcase

        if (xact_end) begin
            d.valid = '0;
            d.arm   = 1'b0;
            st_we   = 1'b0;
            if (q.st == FS_REQ) begin
                d.st  = fetch_ready ? FS_DROP : FS_IDLE;
                d.cnt = '0;
            end else if (q.st == FS_FILL) begin
                d.st = fill_last ? FS_IDLE : FS_DROP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fetch_valid = (q.st == FS_REQ);
    assign fetch_line  = q.fline;
    assign rsp_valid   = q.rsp_valid;

    // R2: accepted request is answered in the following cycle
    a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && rd_req_ready) |=> rsp_valid);

    // R2: resident lines never alias, so at most one slot matches
    a_r2_hit_unique: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R11: transaction end blocks acceptance in its own cycle
    a_r11_end_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        xact_end |-> !rd_req_ready);

    // R9: every line is invalid after a transaction end
    a_r9_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xact_end |=> (q.valid == '0));

    // R12: a pending fetch request stays put until accepted
    a_r12_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready && !xact_end) |=> (fetch_valid && $stable(fetch_line)));

    // R10: no fetch is raised while beats of a discarded burst remain
    a_r10_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_end && (q.st == FS_FILL) && !fill_last) |=> !fetch_valid);

endmodule

// File: rtl/rahead_buf.sv
module rahead_buf #(
    parameter int AW    = 16,
    parameter int DW    = 64,
    parameter int LINES = 4,
    parameter int BEATS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_req_valid,
    input  logic [AW-1:0]                 rd_req_addr,
    input  logic [1:0]                    rd_req_cmd,
    input  logic                          ra_en,
    output logic                          rd_req_ready,
    output logic                          rd_rsp_valid,
    output logic [DW-1:0]                 rd_rsp_data,
    input  logic                          xact_end,
    output logic                          fetch_valid,
    input  logic                          fetch_ready,
    output logic [AW-$clog2(BEATS)-1:0]   fetch_line,
    input  logic                          fill_valid,
    input  logic [DW-1:0]                 fill_data
);
    localparam int IW = $clog2(LINES * BEATS);

    logic          st_we;
    logic          st_re;
    logic [IW-1:0] st_widx;
    logic [IW-1:0] st_ridx;

    rahead_ctrl #(
        .AW    (AW),
        .LINES (LINES),
        .BEATS (BEATS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_valid (rd_req_valid),
        .rd_req_addr  (rd_req_addr),
        .rd_req_cmd   (rd_req_cmd),
        .ra_en        (ra_en),
        .rd_req_ready (rd_req_ready),
        .rsp_valid    (rd_rsp_valid),
        .xact_end     (xact_end),
        .fetch_valid  (fetch_valid),
        .fetch_ready  (fetch_ready),
        .fetch_line   (fetch_line),
        .fill_valid   (fill_valid),
        .st_we        (st_we),
        .st_widx      (st_widx),
        .st_re        (st_re),
        .st_ridx      (st_ridx)
    );

    rahead_store #(
        .LINES (LINES),
        .BEATS (BEATS),
        .DW    (DW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .widx  (st_widx),
        .wdata (fill_data),
        .re    (st_re),
        .ridx  (st_ridx),
        .rdata (rd_rsp_data)
    );

endmodule

// File: tb/rahead_buf_bench.sv
`timescale 1ns/1ps
module rahead_buf_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_req_valid;
    logic [15:0] rd_req_addr;
    logic [1:0]  rd_req_cmd;
    logic        ra_en;
    logic        rd_req_ready;
    logic        rd_rsp_valid;
    logic [63:0] rd_rsp_data;
    logic        xact_end;
    logic        fetch_valid;
    logic        fetch_ready;
    logic [13:0] fetch_line;
    logic        fill_valid;
    logic [63:0] fill_data;

    int tests = 0;
    int fails = 0;
    int nlog  = 0;
    int logl [512];
    int mdelay = 2;

    always #2.5 clk = ~clk;

    rahead_buf u_rahead_buf (
        .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
        .rd_req_cmd(rd_req_cmd), .ra_en(ra_en), .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .xact_end(xact_end),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_line(fetch_line),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [63:0] pat(input int ln, input int b);
        return 64'hD00D_0000_0000_0000 | (64'(ln) << 4) | 64'(b);
    endfunction

    task automatic chk(input string rq, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // processor-bus master model
    initial begin
        fetch_ready = 1'b0;
        fill_valid  = 1'b0;
        fill_data   = '0;
        forever begin
            @(negedge clk);
            if (fetch_valid) begin
                repeat (mdelay) @(negedge clk);
                if (fetch_valid) begin
                    automatic int ln = int'(fetch_line);
                    fetch_ready = 1'b1;
                    logl[nlog % 512] = ln;
                    nlog++;
                    @(negedge clk);
                    fetch_ready = 1'b0;
                    for (int b = 0; b < 4; b++) begin
                        fill_valid = 1'b1;
                        fill_data  = pat(ln, b);
                        if (b > 0) chk("R12 single outstanding fetch", !fetch_valid, 64'(fetch_valid), 64'd0);
                        @(negedge clk);
                    end
                    fill_valid = 1'b0;
                end
            end
        end
    end

    task automatic rd(input int addr, input logic [1:0] cmd, input logic ra, input string rq);
        int waitc = 0;
        bit done  = 0;
        @(negedge clk); #0.2;
        rd_req_valid = 1'b1; rd_req_addr = 16'(addr); rd_req_cmd = cmd; ra_en = ra;
        while (!done) begin
            #0.2;
            if (rd_req_ready) begin
                @(negedge clk); #0.4;
                chk(rq, rd_rsp_valid && (rd_rsp_data == pat(addr >> 2, addr & 3)),
                    rd_rsp_data, pat(addr >> 2, addr & 3));
                rd_req_valid = 1'b0;
                done = 1;
            end else begin
                waitc++;
                if (waitc > 400) begin
                    chk({rq, " timeout"}, 1'b0, 64'd0, 64'd1);
                    rd_req_valid = 1'b0;
                    done = 1;
                end else begin
                    @(negedge clk); #0.2;
                end
            end
        end
    endtask

    task automatic end_xact();
        @(negedge clk); #0.2; xact_end = 1'b1;
        @(negedge clk); #0.2; xact_end = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired, all requirements actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_req_valid = 1'b0; rd_req_addr = '0; rd_req_cmd = '0;
        ra_en = 1'b0; xact_end = 1'b0;
        repeat (4) @(negedge clk);
        #0.4;
        chk("R1 ready low", !rd_req_ready, 64'(rd_req_ready), 0);
        chk("R1 fetch low", !fetch_valid, 64'(fetch_valid), 0);
        chk("R1 rsp low", !rd_rsp_valid, 64'(rd_rsp_valid), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 no fetch after reset", nlog == 0, 64'(nlog), 0);

        // R3, R5: plain read fetches only the demanded line
        nlog = 0;
        rd(16'h0041, 2'd0, 1'b1, "R2 R4 demand data");
        chk("R3 fetch line", nlog == 1 && logl[0] == 16'h10, 64'(logl[0]), 64'h10);
        repeat (30) @(negedge clk);
        chk("R5 no read-ahead on plain read", nlog == 1, 64'(nlog), 1);
        end_xact();

        // R6, R7: read-ahead fills free slots, consumption frees one
        nlog = 0;
        rd(16'h20 * 4, 2'd1, 1'b1, "R2 read-ahead demand");
        repeat (40) @(negedge clk);
        chk("R6 four lines fetched", nlog == 4, 64'(nlog), 4);
        for (int i = 0; i < 4; i++)
            chk("R6 sequential line", logl[i] == 16'h20 + i, 64'(logl[i]), 64'(16'h20 + i));
        for (int b = 0; b < 4; b++) rd(16'h20 * 4 + b, 2'd1, 1'b1, "R2 drain line");
        repeat (30) @(negedge clk);
        chk("R7 next line after consumption", nlog == 5 && logl[4] == 16'h24, 64'(logl[4]), 64'h24);

        // R8: hit accepted while another line fills
        for (int b = 0; b < 4; b++) rd(16'h21 * 4 + b, 2'd1, 1'b1, "R2 drain second line");
        begin
            int g = 0;
            @(negedge clk); #0.2;
            while (!fill_valid && g < 60) begin
                @(negedge clk); #0.2; g++;
            end
            rd_req_valid = 1'b1; rd_req_addr = 16'h22 * 4; rd_req_cmd = 2'd1; ra_en = 1'b1;
            #0.2;
            chk("R8 fill in progress", fill_valid, 64'(fill_valid), 1);
            chk("R8 hit accepted during fill", rd_req_ready, 64'(rd_req_ready), 1);
            @(negedge clk); #0.4;
            chk("R8 data during fill", rd_rsp_valid && rd_rsp_data == pat(16'h22, 0), rd_rsp_data, pat(16'h22, 0));
            rd_req_valid = 1'b0;
        end

        // R9: end invalidates everything
        repeat (30) @(negedge clk);
        end_xact();
        nlog = 0;
        @(negedge clk); #0.2;
        rd_req_valid = 1'b1; rd_req_addr = 16'h22 * 4 + 1; rd_req_cmd = 2'd0; ra_en = 1'b0;
        #0.2;
        chk("R9 held line misses after end", !rd_req_ready, 64'(rd_req_ready), 0);
        rd_req_valid = 1'b0;
        rd(16'h22 * 4 + 1, 2'd0, 1'b0, "R9 refetched data");
        chk("R9 refetch issued", nlog == 1 && logl[0] == 16'h22, 64'(logl[0]), 64'h22);

        // R11: request in the end cycle is refused
        @(negedge clk); #0.2;
        rd_req_valid = 1'b1; rd_req_addr = 16'h22 * 4; xact_end = 1'b1;
        #0.2;
        chk("R11 no accept with end", !rd_req_ready, 64'(rd_req_ready), 0);
        @(negedge clk); #0.2;
        rd_req_valid = 1'b0; xact_end = 1'b0;
        #0.2;
        chk("R11 no response", !rd_rsp_valid, 64'(rd_rsp_valid), 0);

        // R10: end during a burst, same cycle as a fill beat
        mdelay = 0; nlog = 0;
        @(negedge clk); #0.2;
        rd_req_valid = 1'b1; rd_req_addr = 16'h30 * 4 + 2; rd_req_cmd = 2'd0; ra_en = 1'b0;
        begin
            int g = 0;
            while (!(fill_valid && fill_data[3:0] == 4'd1) && g < 60) begin
                @(negedge clk); #0.2; g++;
            end
        end
        rd_req_valid = 1'b0; xact_end = 1'b1;
        @(negedge clk); #0.2; xact_end = 1'b0;
        rd(16'h30 * 4 + 2, 2'd0, 1'b0, "R10 data after discard");
        chk("R10 line fetched again", nlog == 2 && logl[1] == 16'h30, 64'(nlog), 2);

        // sweep of enable and command codes
        mdelay = 1;
        for (int ra = 0; ra < 2; ra++) begin
            for (int c = 0; c < 4; c++) begin
                automatic int base = 16'h100 + (ra * 4 + c) * 16;
                automatic bit pf = (ra == 1) && (c == 1 || c == 2);
                end_xact();
                repeat (10) @(negedge clk);
                nlog = 0;
                for (int i = 0; i < 16; i++) rd(base * 4 + i, 2'(c), 1'(ra), "R2 sweep data");
                repeat (60) @(negedge clk);
                if (pf) chk("R6 sweep fetch count", nlog == 8, 64'(nlog), 8);
                else    chk("R5 sweep fetch count", nlog == 4, 64'(nlog), 4);
                chk("R3 sweep first line", logl[0] == base, 64'(logl[0]), 64'(base));
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule